// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the combinational hazard controller for a five-stage in-order pipeline: Fetch, Decode with register read, Execute, Memory and Writeback. Up to five instructions are in flight at once. The unit watches the register numbers used by the instructions in Decode and Execute. It also watches the destinations, write-enables and load flags of the older instructions further down the pipe. From these it computes four things in the same cycle: operand sources for Execute, write-first bypass selects for the Decode read port, hold signals for the Fetch and Decode pipeline registers, and flush signals that turn stage contents into bubbles.

A redirect is resolved late, in Writeback. A redirect is either a mispredicted branch or an ordinary instruction that writes register 15, the program counter. On a redirect, every younger stage is flushed and fetch restarts at the correct target. A correct prediction costs no cycles, and the unit leaves the pipe alone in that case.

Top module: `hazard_unit`

## Requirements
- R1: For each Execute source, the select is 2 (Memory result) when the Memory stage writes the register file with a destination equal to that source, and the source is not register 15. This holds even when Writeback also matches.
- R2: When R1 does not apply, the select is 1 (Writeback result) when the Writeback stage writes a destination equal to the source, and the source is not register 15.
- R3: When no stage matches, the Execute select is 0 (register-file value). A stage whose write-enable is low never matches.
- R4: An Execute source equal to register 15 always gets select 3 (PC-derived value), whatever the write ports hold.
- R5: Each Decode bypass output is 1 exactly when Writeback writes a destination equal to that Decode source and the source is not register 15.
- R6: A load-use hazard exists when Execute holds a load that writes a destination other than register 15, and that destination equals either Decode source. With no redirect pending, the hazard raises hold_f and hold_d, raises flush_e (a bubble into Execute), and leaves flush_d and flush_m low.
- R7: A redirect is raised by either bp_miss or pc_wr. It drives flush_d, flush_e and flush_m high and hold_f and hold_d low.
- R8: With no redirect and no load-use hazard, all hold and flush outputs are 0.
- R9: When a redirect and a load-use hazard occur in the same cycle, the redirect wins: both holds are 0 and all three flushes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 4 | First source register of the Execute instruction |
| ex_rs2 | input | 4 | Second source register of the Execute instruction |
| dc_rs1 | input | 4 | First source register of the Decode instruction |
| dc_rs2 | input | 4 | Second source register of the Decode instruction |
| ex_rd | input | 4 | Destination of the Execute instruction |
| ex_we | input | 1 | Execute instruction writes the register file |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 4 | Destination of the Memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes the register file |
| wb_rd | input | 4 | Destination of the Writeback instruction |
| wb_we | input | 1 | Writeback instruction writes the register file |
| bp_miss | input | 1 | Branch outcome differs from the prediction |
| pc_wr | input | 1 | Ordinary instruction writes register 15 |
| ex_sel_a | output | 2 | Source for Execute operand A: 0 RF, 1 WB, 2 MEM, 3 PC |
| ex_sel_b | output | 2 | Source for Execute operand B, same coding |
| dc_byp_a | output | 1 | Decode read port A takes the Writeback value |
| dc_byp_b | output | 1 | Decode read port B takes the Writeback value |
| hold_f | output | 1 | Keep the Fetch pipeline register unchanged |
| hold_d | output | 1 | Keep the Decode pipeline register unchanged |
| flush_d | output | 1 | Replace Decode contents with a bubble |
| flush_e | output | 1 | Replace Execute contents with a bubble |
| flush_m | output | 1 | Replace Memory contents with a bubble |

## Verification
Two pairs of functions can land in the same cycle. A load-use hold can coincide with a late redirect, and Memory and Writeback forwarding can both match one Execute source. The bench forces both collisions with directed cases: a load whose destination feeds Decode while bp_miss or pc_wr is high, and identical destinations in the Memory and Writeback stages. It then confirms that the flush pattern replaces the hold and that the Memory select wins. Random register numbers drawn from a narrowed range keep such overlaps frequent throughout the random phase.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
    parameter int REG_W  = 4;
    parameter int N_SRC  = 2;
    localparam logic [REG_W-1:0] PC_REG = {REG_W{1'b1}};

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_WB  = 2'd1,
        SRC_MEM = 2'd2,
        SRC_PC  = 2'd3
    } opnd_src_e;

    typedef struct packed {
        reg_idx_t rd;
        logic     we;
    } wr_port_t;

    typedef struct packed {
        logic hold_f;
        logic hold_d;
        logic flush_d;
        logic flush_e;
        logic flush_m;
    } pipe_ctl_t;

    function automatic logic dest_hits(reg_idx_t src, wr_port_t w);
        return w.we && (w.rd == src) && (src != PC_REG);
    endfunction
endpackage

// File: rtl/hzu_opnd_select.sv
module hzu_opnd_select
    import hzu_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  reg_idx_t  [NS-1:0] src,
    input  wr_port_t           mem_w,
    input  wr_port_t           wb_w,
    output opnd_src_e [NS-1:0] sel
);
    for (genvar g = 0; g < NS; g++) begin : g_src
        always_comb begin
            if (src[g] == PC_REG)              sel[g] = SRC_PC;
            else if (dest_hits(src[g], mem_w)) sel[g] = SRC_MEM;
            else if (dest_hits(src[g], wb_w))  sel[g] = SRC_WB;
            else                               sel[g] = SRC_RF;
        end
    end
endmodule

// File: rtl/hzu_load_use.sv
module hzu_load_use
    import hzu_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  reg_idx_t [NS-1:0] dc_src,
    input  wr_port_t          ex_w,
    input  logic              ex_load,
    output logic              hazard
);
    logic [NS-1:0] hit;
    for (genvar g = 0; g < NS; g++) begin : g_cmp
        assign hit[g] = ex_w.we && (ex_w.rd != PC_REG) && (ex_w.rd == dc_src[g]);
    end
    assign hazard = ex_load && (|hit);
endmodule

// File: rtl/hzu_flush_ctrl.sv
module hzu_flush_ctrl
    import hzu_pkg::*;
(
    input  logic      load_use,
    input  logic      redirect,
    output pipe_ctl_t ctl
);
    always_comb begin
        ctl = '0;
        if (redirect) begin
            ctl.flush_d = 1'b1;
            ctl.flush_e = 1'b1;
            ctl.flush_m = 1'b1;
        end else if (load_use) begin
            ctl.hold_f  = 1'b1;
            ctl.hold_d  = 1'b1;
            ctl.flush_e = 1'b1;
        end
    end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hzu_pkg::*;
(
    input  logic [3:0] ex_rs1,
    input  logic [3:0] ex_rs2,
    input  logic [3:0] dc_rs1,
    input  logic [3:0] dc_rs2,
    input  logic [3:0] ex_rd,
    input  logic       ex_we,
    input  logic       ex_load,
    input  logic [3:0] mem_rd,
    input  logic       mem_we,
    input  logic [3:0] wb_rd,
    input  logic       wb_we,
    input  logic       bp_miss,
    input  logic       pc_wr,
    output logic [1:0] ex_sel_a,
    output logic [1:0] ex_sel_b,
    output logic       dc_byp_a,
    output logic       dc_byp_b,
    output logic       hold_f,
    output logic       hold_d,
    output logic       flush_d,
    output logic       flush_e,
    output logic       flush_m
);
    reg_idx_t  [N_SRC-1:0] ex_src, dc_src;
    opnd_src_e [N_SRC-1:0] ex_sel;
    wr_port_t              ex_w, mem_w, wb_w;
    logic                  load_use;
    pipe_ctl_t             ctl;

    assign ex_src = {ex_rs2, ex_rs1};
    assign dc_src = {dc_rs2, dc_rs1};
    assign ex_w   = '{rd: ex_rd,  we: ex_we};
    assign mem_w  = '{rd: mem_rd, we: mem_we};
    assign wb_w   = '{rd: wb_rd,  we: wb_we};

    hzu_opnd_select #(.NS(N_SRC)) u_sel (
        .src   (ex_src),
        .mem_w (mem_w),
        .wb_w  (wb_w),
        .sel   (ex_sel)
    );

    hzu_load_use #(.NS(N_SRC)) u_lu (
        .dc_src  (dc_src),
        .ex_w    (ex_w),
        .ex_load (ex_load),
        .hazard  (load_use)
    );

    hzu_flush_ctrl u_fc (
        .load_use (load_use),
        .redirect (bp_miss | pc_wr),
        .ctl      (ctl)
    );

    logic [N_SRC-1:0] dc_byp;
    for (genvar g = 0; g < N_SRC; g++) begin : g_byp
        assign dc_byp[g] = dest_hits(dc_src[g], wb_w);
    end

    assign ex_sel_a = ex_sel[0];
    assign ex_sel_b = ex_sel[1];
    assign dc_byp_a = dc_byp[0];
    assign dc_byp_b = dc_byp[1];
    assign hold_f   = ctl.hold_f;
    assign hold_d   = ctl.hold_d;
    assign flush_d  = ctl.flush_d;
    assign flush_e  = ctl.flush_e;
    assign flush_m  = ctl.flush_m;
endmodule

// File: rtl/hazard_unit_checker.sv
module hazard_unit_checker (
    input logic [3:0] ex_rs1,
    input logic [3:0] mem_rd,
    input logic       mem_we,
    input logic [3:0] wb_rd,
    input logic       wb_we,
    input logic [3:0] dc_rs1,
    input logic       bp_miss,
    input logic       pc_wr,
    input logic [1:0] ex_sel_a,
    input logic       dc_byp_a,
    input logic       hold_f,
    input logic       hold_d,
    input logic       flush_d,
    input logic       flush_e,
    input logic       flush_m
);
    always_comb begin
        a_r1_mem_first: assert (!(mem_we && mem_rd == ex_rs1 && ex_rs1 != 4'hF) || ex_sel_a == 2'd2);
        a_r4_pc_source: assert (ex_rs1 != 4'hF || ex_sel_a == 2'd3);
        a_r3_no_match:  assert (!((!mem_we || mem_rd != ex_rs1) && (!wb_we || wb_rd != ex_rs1)
                                  && ex_rs1 != 4'hF) || ex_sel_a == 2'd0);
        a_r5_dc_bypass: assert (dc_byp_a == (wb_we && wb_rd == dc_rs1 && dc_rs1 != 4'hF));
        a_r7_redirect:  assert (!(bp_miss || pc_wr) || (flush_d && flush_e && flush_m && !hold_f && !hold_d));
        a_r6_hold_pair: assert (hold_f == hold_d && (!hold_f || (flush_e && !flush_d && !flush_m)));
        a_r8_quiet:     assert ((bp_miss || pc_wr) || hold_f || !(flush_d || flush_e || flush_m));
    end
endmodule

bind hazard_unit hazard_unit_checker u_chk (
    .ex_rs1   (ex_rs1),
    .mem_rd   (mem_rd),
    .mem_we   (mem_we),
    .wb_rd    (wb_rd),
    .wb_we    (wb_we),
    .dc_rs1   (dc_rs1),
    .bp_miss  (bp_miss),
    .pc_wr    (pc_wr),
    .ex_sel_a (ex_sel_a),
    .dc_byp_a (dc_byp_a),
    .hold_f   (hold_f),
    .hold_d   (hold_d),
    .flush_d  (flush_d),
    .flush_e  (flush_e),
    .flush_m  (flush_m)
);

// File: tb/hazard_unit_tb_top.sv
module hazard_unit_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [3:0] ex_rs1, ex_rs2, dc_rs1, dc_rs2, ex_rd, mem_rd, wb_rd;
    logic ex_we, ex_load, mem_we, wb_we, bp_miss, pc_wr;
    logic [1:0] ex_sel_a, ex_sel_b;
    logic dc_byp_a, dc_byp_b, hold_f, hold_d, flush_d, flush_e, flush_m;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hazard_unit dut_i (.*);

    function automatic logic [1:0] exp_sel(logic [3:0] s);
        if (s == 4'hF) return 2'd3;                       // R4
        if (mem_we && mem_rd == s) return 2'd2;           // R1
        if (wb_we && wb_rd == s) return 2'd1;             // R2
        return 2'd0;                                      // R3
    endfunction

    function automatic logic exp_byp(logic [3:0] s);
        return wb_we && wb_rd == s && s != 4'hF;          // R5
    endfunction

    function automatic logic [4:0] exp_ctl();   // {hold_f,hold_d,flush_d,flush_e,flush_m}
        logic lu;
        lu = ex_load && ex_we && ex_rd != 4'hF && (ex_rd == dc_rs1 || ex_rd == dc_rs2);
        if (bp_miss || pc_wr) return 5'b00111;            // R7, R9
        if (lu) return 5'b11010;                          // R6
        return 5'b00000;                                  // R8
    endfunction

    task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic string ctl_tag();
        logic lu;
        lu = ex_load && ex_we && ex_rd != 4'hF && (ex_rd == dc_rs1 || ex_rd == dc_rs2);
        if ((bp_miss || pc_wr) && lu) return "R9";
        if (bp_miss || pc_wr) return "R7";
        if (lu) return "R6";
        return "R8";
    endfunction

    function automatic string sel_tag(logic [1:0] e);
        case (e)
            2'd3: return "R4";
            2'd2: return "R1";
            2'd1: return "R2";
            default: return "R3";
        endcase
    endfunction

    task automatic check_all();
        @(negedge clk);
        chk(sel_tag(exp_sel(ex_rs1)), {3'b0, ex_sel_a}, {3'b0, exp_sel(ex_rs1)});
        chk(sel_tag(exp_sel(ex_rs2)), {3'b0, ex_sel_b}, {3'b0, exp_sel(ex_rs2)});
        chk("R5", {3'b0, dc_byp_a, dc_byp_b}, {3'b0, exp_byp(dc_rs1), exp_byp(dc_rs2)});
        chk(ctl_tag(), {hold_f, hold_d, flush_d, flush_e, flush_m}, exp_ctl());
    endtask

    task automatic clear();
        @(posedge clk);
        {ex_rs1, ex_rs2, dc_rs1, dc_rs2, ex_rd, mem_rd, wb_rd} = '0;
        {ex_we, ex_load, mem_we, wb_we, bp_miss, pc_wr} = '0;
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        clear();
        check_all();                                      // idle state, R8 and R3

        clear(); ex_rs1 = 4'd3; mem_rd = 4'd3; mem_we = 1; wb_rd = 4'd3; wb_we = 1;
        check_all();                                      // R1 both stages match
        clear(); ex_rs2 = 4'd6; wb_rd = 4'd6; wb_we = 1; mem_rd = 4'd6; mem_we = 0;
        check_all();                                      // R2 with disabled Memory
        clear(); ex_rs1 = 4'hF; ex_rs2 = 4'hF; mem_rd = 4'hF; mem_we = 1; wb_rd = 4'hF; wb_we = 1;
        dc_rs1 = 4'hF;
        check_all();                                      // R4 and R5 register 15
        clear(); dc_rs2 = 4'd9; wb_rd = 4'd9; wb_we = 1;
        check_all();                                      // R5 write-first
        clear(); ex_load = 1; ex_we = 1; ex_rd = 4'd4; dc_rs2 = 4'd4;
        check_all();                                      // R6
        clear(); ex_load = 1; ex_we = 1; ex_rd = 4'd4; dc_rs1 = 4'd4; bp_miss = 1;
        check_all();                                      // R9 branch miss
        clear(); ex_load = 1; ex_we = 1; ex_rd = 4'd2; dc_rs1 = 4'd2; pc_wr = 1;
        check_all();                                      // R9 PC write
        clear(); ex_load = 1; ex_we = 1; ex_rd = 4'hF; dc_rs1 = 4'hF;
        check_all();                                      // R6 excludes register 15
        clear(); ex_load = 0; ex_we = 1; ex_rd = 4'd5; dc_rs1 = 4'd5;
        check_all();                                      // R8 non-load

        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            ex_rs1 = 4'($urandom_range(0, 15)); ex_rs2 = 4'($urandom_range(12, 15));
            dc_rs1 = 4'($urandom_range(12, 15)); dc_rs2 = 4'($urandom_range(0, 15));
            ex_rd  = 4'($urandom_range(12, 15)); mem_rd = 4'($urandom_range(12, 15));
            wb_rd  = 4'($urandom_range(12, 15));
            ex_we = 1'($urandom); ex_load = 1'($urandom); mem_we = 1'($urandom);
            wb_we = 1'($urandom);
            bp_miss = ($urandom_range(0, 7) == 0); pc_wr = ($urandom_range(0, 7) == 0);
            check_all();
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule